// File: doc/BRIEF.md
# Output Clock Delay Trim Register

This block holds the two delay settings for an output clock and reports the total delay they add. The fine setting counts 25 ps units and takes any legal value in a single write. The coarse setting drives a clock generator that can only move forward. For that reason the register never loads it directly. It can only advance it by one unit at a time, or clear it to zero.

Each unit of the coarse setting is worth either 400 ps or 330 ps. A one-bit mode input selects which. The block computes the total delay in picoseconds combinationally from the held settings and the mode. Each coarse advance that actually takes effect emits a one-cycle pulse. A downstream serial programmer can use that pulse to send the matching increment command to the clock chip.

Top module: `delay_trim_reg`

## Requirements
- R1: While reset is asserted (`rstN` low, asynchronous), `fineVal` is 0, `coarseVal` is 0, `stepPulse` is 0 and `totalPs` is 0.
- R2: A clock edge with `fineWrEn` high and `fineWrData` in 0..23 loads that value into `fineVal`, and it is visible after that edge.
- R3: A clock edge with `fineWrEn` high and `fineWrData` above 23 leaves `fineVal` at its previous value.
- R4: A clock edge with `stepReq` high and `clearReq` low raises `coarseVal` by exactly one when it is below 7. At 7 it stays at 7 and never wraps.
- R5: A clock edge with `clearReq` high sets `coarseVal` to 0.
- R6: When `stepReq` and `clearReq` are high at the same edge, the clear wins: `coarseVal` becomes 0 and no `stepPulse` is produced.
- R7: `stepPulse` is high for exactly the one cycle after an edge at which `coarseVal` was incremented. It is low after ignored or cleared steps.
- R8: `totalPs` equals `fineVal*25 + coarseVal*400` when `pllSel` is 0, and `fineVal*25 + coarseVal*330` when `pllSel` is 1. It follows `pllSel` in the same cycle.
- R9: A fine write and an effective step at the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fineWrEn | input | 1 | Fine setting write enable |
| fineWrData | input | 5 | Fine setting value, 25 ps units |
| stepReq | input | 1 | Request to advance the coarse setting by one |
| clearReq | input | 1 | Request to clear the coarse setting |
| pllSel | input | 1 | Coarse unit: 0 = 400 ps, 1 = 330 ps |
| fineVal | output | 5 | Held fine setting |
| coarseVal | output | 3 | Held coarse setting |
| totalPs | output | 12 | Total added delay in picoseconds |
| stepPulse | output | 1 | One-cycle pulse per effective coarse advance |

## Verification
Two pairs of operations can land on the same clock edge. The first pair is a coarse advance and a coarse clear. The vector table raises both strobes in one row while the coarse setting is non-zero, and it is judged correct only if the setting reads zero with no pulse. The second pair is a fine write and a coarse advance. A combined row must show the new fine value, the incremented coarse value and a pulse all together, with the total recomputed from the bench's own formula for the selected mode.

// File: rtl/dly_trim_pkg.sv
package dly_trim_pkg;
  // Strobes from the control decode to the register datapath
  typedef struct packed {
    logic fineLoad;
    logic coarseInc;
    logic coarseClr;
  } trimStrobes_t;
endpackage

// File: rtl/dly_trim_ctrl.sv
module dly_trim_ctrl
  import dly_trim_pkg::*;
#(
  parameter int FINE_W     = 5,
  parameter int FINE_MAX   = 23,
  parameter int COARSE_W   = 3,
  parameter int COARSE_MAX = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fineWrEn,
  input  logic [FINE_W-1:0]   fineWrData,
  input  logic                stepReq,
  input  logic                clearReq,
  input  logic [COARSE_W-1:0] coarseNow,
  output trimStrobes_t        strobes
);
  localparam logic [FINE_W-1:0]   FINE_LIMIT   = FINE_W'(FINE_MAX);
  localparam logic [COARSE_W-1:0] COARSE_LIMIT = COARSE_W'(COARSE_MAX);

  logic atTop;
  assign atTop = (coarseNow == COARSE_LIMIT);

  always_comb begin
    strobes           = '0;
    strobes.fineLoad  = fineWrEn && (fineWrData <= FINE_LIMIT);
    strobes.coarseClr = clearReq;
    // the clear takes priority; a step at the top of the range is dropped
    strobes.coarseInc = stepReq && !clearReq && !atTop;
  end

  AST_NO_INC_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (atTop && !clearReq) |=> (coarseNow == COARSE_LIMIT)); // R4
endmodule

// File: rtl/dly_trim_datapath.sv
module dly_trim_datapath
  import dly_trim_pkg::*;
#(
  parameter int FINE_W          = 5,
  parameter int FINE_MAX        = 23,
  parameter int FINE_UNIT_PS    = 25,
  parameter int COARSE_W        = 3,
  parameter int COARSE_UNIT_PS  = 400,
  parameter int COARSE_ALT_PS   = 330,
  parameter int TOTAL_W         = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  trimStrobes_t        strobes,
  input  logic [FINE_W-1:0]   fineWrData,
  input  logic                pllSel,
  output logic [FINE_W-1:0]   fineQ,
  output logic [COARSE_W-1:0] coarseQ,
  output logic [TOTAL_W-1:0]  totalPs,
  output logic                stepPulse
);
  localparam logic [TOTAL_W-1:0] FINE_UNIT  = TOTAL_W'(FINE_UNIT_PS);
  localparam logic [TOTAL_W-1:0] UNIT_MAIN  = TOTAL_W'(COARSE_UNIT_PS);
  localparam logic [TOTAL_W-1:0] UNIT_ALT   = TOTAL_W'(COARSE_ALT_PS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fineQ <= '0;
    end else if (strobes.fineLoad) begin
      fineQ <= fineWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coarseQ   <= '0;
      stepPulse <= 1'b0;
    end else begin
      stepPulse <= strobes.coarseInc && !strobes.coarseClr;
      if (strobes.coarseClr) begin
        coarseQ <= '0;
      end else if (strobes.coarseInc) begin
        coarseQ <= coarseQ + 1'b1;
      end
    end
  end

  logic [TOTAL_W-1:0] fineTerm, coarseTerm, coarseUnit;
  assign coarseUnit = pllSel ? UNIT_ALT : UNIT_MAIN;
  assign fineTerm   = TOTAL_W'(fineQ) * FINE_UNIT;
  assign coarseTerm = TOTAL_W'(coarseQ) * coarseUnit;
  assign totalPs    = fineTerm + coarseTerm;

  AST_FINE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    fineQ <= FINE_W'(FINE_MAX)); // R3
  AST_COARSE_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(coarseQ) |-> ((coarseQ == $past(coarseQ) + 1'b1) || (coarseQ == '0))); // R4
  AST_PULSE_MATCHES_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse |-> (coarseQ == $past(coarseQ) + 1'b1)); // R7
endmodule

// File: rtl/delay_trim_reg.sv
module delay_trim_reg
  import dly_trim_pkg::*;
#(
  parameter int FINE_W         = 5,
  parameter int FINE_MAX       = 23,
  parameter int FINE_UNIT_PS   = 25,
  parameter int COARSE_W       = 3,
  parameter int COARSE_MAX     = 7,
  parameter int COARSE_UNIT_PS = 400,
  parameter int COARSE_ALT_PS  = 330,
  parameter int TOTAL_W        = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fineWrEn,
  input  logic [FINE_W-1:0]   fineWrData,
  input  logic                stepReq,
  input  logic                clearReq,
  input  logic                pllSel,
  output logic [FINE_W-1:0]   fineVal,
  output logic [COARSE_W-1:0] coarseVal,
  output logic [TOTAL_W-1:0]  totalPs,
  output logic                stepPulse
);
  trimStrobes_t strobes;

  dly_trim_ctrl #(
    .FINE_W(FINE_W), .FINE_MAX(FINE_MAX),
    .COARSE_W(COARSE_W), .COARSE_MAX(COARSE_MAX)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .fineWrEn(fineWrEn), .fineWrData(fineWrData),
    .stepReq(stepReq), .clearReq(clearReq),
    .coarseNow(coarseVal), .strobes(strobes)
  );

  dly_trim_datapath #(
    .FINE_W(FINE_W), .FINE_MAX(FINE_MAX), .FINE_UNIT_PS(FINE_UNIT_PS),
    .COARSE_W(COARSE_W), .COARSE_UNIT_PS(COARSE_UNIT_PS),
    .COARSE_ALT_PS(COARSE_ALT_PS), .TOTAL_W(TOTAL_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .fineWrData(fineWrData), .pllSel(pllSel),
    .fineQ(fineVal), .coarseQ(coarseVal),
    .totalPs(totalPs), .stepPulse(stepPulse)
  );

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (coarseVal == '0 && !stepPulse)); // R6
  AST_FINE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (fineWrEn && fineWrData <= FINE_W'(FINE_MAX)) |=> (fineVal == $past(fineWrData))); // R2
endmodule

// File: tb/test_delay_trim_reg.sv
module test_delay_trim_reg;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       fwe;
    logic [4:0] fdat;
    logic       st;
    logic       cl;
    logic       pll;
    logic [4:0] eFine;
    logic [2:0] eCoarse;
    logic       ePulse;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd10, 1'b0, 1'b0, 1'b0, 5'd10, 3'd0, 1'b0}, // R2
    '{1'b1, 5'd23, 1'b0, 1'b0, 1'b0, 5'd23, 3'd0, 1'b0}, // R2 top
    '{1'b1, 5'd24, 1'b0, 1'b0, 1'b0, 5'd23, 3'd0, 1'b0}, // R3
    '{1'b1, 5'd31, 1'b0, 1'b0, 1'b1, 5'd23, 3'd0, 1'b0}, // R3
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 5'd23, 3'd1, 1'b1}, // R4 R7
    '{1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 5'd23, 3'd1, 1'b0}, // R7 R8
    '{1'b1, 5'd5,  1'b1, 1'b0, 1'b1, 5'd5,  3'd2, 1'b1}, // R9
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 5'd5,  3'd3, 1'b1}, // R4
    '{1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 5'd5,  3'd0, 1'b0}, // R6
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b1, 5'd5,  3'd1, 1'b1}, // R4
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 5'd5,  3'd2, 1'b1},
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b1, 5'd5,  3'd3, 1'b1},
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 5'd5,  3'd4, 1'b1},
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b1, 5'd5,  3'd5, 1'b1},
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 5'd5,  3'd6, 1'b1},
    '{1'b1, 5'd23, 1'b1, 1'b0, 1'b1, 5'd23, 3'd7, 1'b1}, // R9 to top
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 5'd23, 3'd7, 1'b0}, // R4 no wrap
    '{1'b0, 5'd0,  1'b0, 1'b1, 1'b1, 5'd23, 3'd0, 1'b0}, // R5
    '{1'b1, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0,  3'd0, 1'b0}  // R2 zero
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fineWrEn = 1'b0;
  logic [4:0] fineWrData = '0;
  logic       stepReq = 1'b0;
  logic       clearReq = 1'b0;
  logic       pllSel = 1'b0;
  logic [4:0] fineVal;
  logic [2:0] coarseVal;
  logic [11:0] totalPs;
  logic       stepPulse;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  delay_trim_reg i_delay_trim_reg (
    .clk(clk), .rstN(rstN),
    .fineWrEn(fineWrEn), .fineWrData(fineWrData),
    .stepReq(stepReq), .clearReq(clearReq), .pllSel(pllSel),
    .fineVal(fineVal), .coarseVal(coarseVal),
    .totalPs(totalPs), .stepPulse(stepPulse)
  );

  function automatic int expTotal(int f, int c, logic p);
    return f * 25 + c * (p ? 330 : 400);
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkAll(string req, int f, int c, int p, logic pll);
    check({req, " fine"}, int'(fineVal), f);
    check({req, " coarse"}, int'(coarseVal), c);
    check({req, " pulse"}, int'(stepPulse), p);
    check({req, " total R8"}, int'(totalPs), expTotal(f, c, pll));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    #(CLK_PERIOD * 2 + 1);
    checkAll("R1 reset", 0, 0, 0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      fineWrEn   = VECS[i].fwe;
      fineWrData = VECS[i].fdat;
      stepReq    = VECS[i].st;
      clearReq   = VECS[i].cl;
      pllSel     = VECS[i].pll;
      @(negedge clk);
      checkAll($sformatf("vec%0d", i), int'(VECS[i].eFine),
               int'(VECS[i].eCoarse), int'(VECS[i].ePulse), VECS[i].pll);
    end
    fineWrEn = 1'b0; stepReq = 1'b0; clearReq = 1'b0;

    // R8: mode flips the total without a clock edge
    fineWrEn = 1'b1; fineWrData = 5'd4; @(negedge clk); fineWrEn = 1'b0;
    stepReq = 1'b1; @(negedge clk); stepReq = 1'b0;
    @(negedge clk);
    pllSel = 1'b0; #1;
    check("R8 mode0", int'(totalPs), 100 + 400);
    pllSel = 1'b1; #1;
    check("R8 mode1", int'(totalPs), 100 + 330);
    check("R7 pulse single cycle", int'(stepPulse), 0);

    // R3: illegal write after legal state holds value
    @(negedge clk);
    fineWrEn = 1'b1; fineWrData = 5'd30; @(negedge clk); fineWrEn = 1'b0;
    check("R3 hold", int'(fineVal), 4);

    // R1: asynchronous reset mid-run
    #2 rstN = 1'b0; #1;
    checkAll("R1 async", 0, 0, 0, pllSel);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(coarseVal), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule